// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block is the control logic that sits behind the strobe pins of an extended-data-out DRAM. It samples the active-low row strobe, column strobe, write strobe and output-enable strobe, together with the multiplexed address and the input data, on a fast internal clock. Each time the row strobe falls it works out which kind of cycle has started. The possible cycles are a read, an early write, a read-write, a row-only refresh, a column-before-row refresh, a hidden refresh, self refresh and test-mode entry. Later edges of the column and write strobes refine the cycle type inside the open row.

The block owns the internal refresh row counter, whose width matches the number of row address bits. It also owns the self-refresh entry timer and periodic refresh tick, and the test-mode flag. It decides when the data pins drive and holds read data after the column strobe rises, as extended-data-out parts do. The storage array is a small behavioural memory indexed by the low row and column address bits. The current cycle type, the test-mode flag, the self-refresh state, the counter and the most recently refreshed row are brought out as status ports.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: After reset, `cyc_type` is 0 (idle), `test_mode`, `self_refresh` and `dq_oe` are 0, and `rfsh_ctr` is 0.
- R2: If the column strobe is low when the row strobe falls (and the test key below is not met), the cycle is a column-before-row refresh. `cyc_type` becomes 5, `last_ref_row` takes the old counter value and `rfsh_ctr` advances by one. The address pins have no effect on the counter or on the stored data.
- R3: `rfsh_ctr` is ROW_ADDR_W bits wide and wraps from all ones to zero.
- R4: If the write and column strobes are both low when the row strobe falls, and address bits 0 to 9 are all ones, `cyc_type` becomes 8 and `test_mode` sets. The cycle still counts as a counter refresh. With any of those ten bits at zero, the cycle is a plain refresh of type 5.
- R5: A column-before-row refresh or a hidden refresh clears `test_mode` at the row strobe fall. A row-only refresh clears it when the row strobe rises. A further test-entry cycle leaves it set.
- R6: A column strobe fall inside an open row with the write strobe high is a read (`cyc_type` 1). `dq_out` shows the word stored at the latched row and the current column, and `dq_oe` is 1 while output enable is low.
- R7: A column strobe fall with the write strobe already low is an early write (`cyc_type` 2). It stores `dq_in` at the addressed cell, and `dq_oe` stays 0 throughout.
- R8: A write strobe fall during a read, while both strobes are still low, turns the cycle into a read-write (`cyc_type` 3). Read data has been driven first. The fall then stores `dq_in` at the same cell and turns `dq_oe` off.
- R9: Read data stays driven after the column strobe rises while the row strobe is still low. `dq_oe` drops once both strobes are high, and it follows output enable going high or low again.
- R10: A row strobe rise and fall with the column strobe held low from a read is a hidden refresh. `cyc_type` becomes 6 and the counter advances by one, while `dq_out` and `dq_oe` keep the read data.
- R11: After a column-before-row refresh, if both strobes stay low for SELF_ENTRY_CYC further cycles, `self_refresh` sets and `cyc_type` reads 7. If the column strobe rises earlier, there is no entry. Self refresh ends when the row strobe rises.
- R12: In self refresh, `rfsh_ctr` advances by one every SELF_PERIOD_CYC cycles, counted from entry.
- R13: A row strobe fall with the column strobe high gives `cyc_type` 4 (row-only refresh) until a column strobe fall refines it. `last_ref_row` takes the full row address and `rfsh_ctr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_ADDR_W | Multiplexed row and column address |
| dq_in | input | DQ_W | Write data from the pins |
| dq_out | output | DQ_W | Read data toward the pins |
| dq_oe | output | 1 | Drive enable for the data pins |
| cyc_type | output | 4 | Current cycle code |
| test_mode | output | 1 | Test mode active |
| self_refresh | output | 1 | Self refresh active |
| rfsh_ctr | output | ROW_ADDR_W | Internal refresh row counter |
| last_ref_row | output | ROW_ADDR_W | Row covered by the latest refresh |

## Verification
Every strobe and address change passes two registers, one sampling the pins and one detecting the edge, before a result appears. The cycle type, counter, test flag and data-pin drive are therefore due two clocks after the bench drives a pin, and the bench drives on the falling clock edge and samples two falling edges later. Output enable reaches `dq_oe` through one register only, so those checks sample one falling edge after the change. Self-refresh entry is due SELF_ENTRY_CYC clocks after the refresh is classified, and each counter tick SELF_PERIOD_CYC clocks after the previous one. The bench samples one cycle before and exactly at each of these points.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;

   typedef enum logic [3:0] {
      CYC_IDLE   = 4'd0,
      CYC_READ   = 4'd1,
      CYC_EWRITE = 4'd2,
      CYC_RDWR   = 4'd3,
      CYC_ROWREF = 4'd4,
      CYC_CBR    = 4'd5,
      CYC_HIDDEN = 4'd6,
      CYC_SELF   = 4'd7,
      CYC_TESTIN = 4'd8
   } cyc_e;

endpackage

// File: rtl/dram_strobe_sampler.sv
module dram_strobe_sampler #(
   parameter int ADDR_W = 12,
   parameter int DQ_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   din,
   output logic              ras_low,
   output logic              cas_low,
   output logic              we_low,
   output logic              oe_low,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DQ_W-1:0]   din_q,
   output logic              ras_fall,
   output logic              ras_rise,
   output logic              cas_fall,
   output logic              cas_rise,
   output logic              we_fall
);

   localparam int NSTB  = 4;
   localparam int NFALL = 3;

   logic [NSTB-1:0]  raw;
   logic [NSTB-1:0]  cur_q;
   logic [NSTB-1:0]  prv_q;
   logic [NFALL-1:0] fall_v;

   assign raw = {oe_n, we_n, cas_n, ras_n};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '1;
         prv_q  <= '1;
         addr_q <= '0;
         din_q  <= '0;
      end else begin
         cur_q  <= raw;
         prv_q  <= cur_q;
         addr_q <= addr;
         din_q  <= din;
      end
   end

   // falling-edge detectors for row, column and write strobes
   for (genvar i = 0; i < NFALL; i++) begin : g_fall
      assign fall_v[i] = prv_q[i] & ~cur_q[i];
   end

   assign ras_fall = fall_v[0];
   assign cas_fall = fall_v[1];
   assign we_fall  = fall_v[2];
   assign ras_rise = ~prv_q[0] & cur_q[0];
   assign cas_rise = ~prv_q[1] & cur_q[1];

   assign ras_low = ~cur_q[0];
   assign cas_low = ~cur_q[1];
   assign we_low  = ~cur_q[2];
   assign oe_low  = ~cur_q[3];

endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
   parameter int ROW_W      = 12,
   parameter int ENTRY_CYC  = 10000,
   parameter int PERIOD_CYC = 1563
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cbr_start,
   input  logic             bump,
   input  logic             ras_low,
   input  logic             cas_low,
   output logic [ROW_W-1:0] row,
   output logic             self_active
);

   localparam int WAIT_W = $clog2(ENTRY_CYC + 1);
   localparam int PER_W  = $clog2(PERIOD_CYC + 1);
   localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(ENTRY_CYC - 1);
   localparam logic [PER_W-1:0]  PER_LAST  = PER_W'(PERIOD_CYC - 1);

   initial begin
      assert (ENTRY_CYC >= 2) else $error("ENTRY_CYC must be at least 2");
      assert (PERIOD_CYC >= 1) else $error("PERIOD_CYC must be at least 1");
   end

   logic              armed_q;
   logic [WAIT_W-1:0] wait_q;
   logic [PER_W-1:0]  per_q;
   logic              tick;

   assign tick = self_active && ras_low && (per_q == PER_LAST);

   // entry timer: both strobes must stay low the whole window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q     <= 1'b0;
         wait_q      <= '0;
         self_active <= 1'b0;
         per_q       <= '0;
      end else begin
         if (cbr_start) begin
            armed_q <= 1'b1;
            wait_q  <= '0;
         end else if (armed_q) begin
            if (!ras_low || !cas_low) begin
               armed_q <= 1'b0;
            end else if (wait_q == WAIT_LAST) begin
               armed_q     <= 1'b0;
               self_active <= 1'b1;
               per_q       <= '0;
            end else begin
               wait_q <= wait_q + WAIT_W'(1);
            end
         end
         if (self_active) begin
            if (!ras_low) begin
               self_active <= 1'b0;
            end else if (tick) begin
               per_q <= '0;
            end else begin
               per_q <= per_q + PER_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
      end else if (bump || tick) begin
         row <= row + ROW_W'(1);
      end
   end

   // R2 R3 R12
   row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(row) |-> row == ROW_W'($past(row) + ROW_W'(1)));

   // R11
   self_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      self_active |-> $past(ras_low));

endmodule

// File: rtl/dram_cell_array.sv
module dram_cell_array #(
   parameter int AW   = 6,
   parameter int DQ_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  logic [AW-1:0]   rd_addr,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DQ_W-1:0] wr_data,
   output logic [DQ_W-1:0] rd_data
);

   localparam int DEPTH = 1 << AW;

   initial begin
      assert (AW <= 10) else $error("behavioural array too large");
   end

   logic [DQ_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         rd_data <= mem[rd_addr];
      end
   end

endmodule

// File: rtl/dram_strobe_ctrl.sv
module dram_strobe_ctrl
   import dram_cyc_pkg::*;
#(
   parameter int ROW_ADDR_W      = 12,
   parameter int DQ_W            = 4,
   parameter int MEM_ROW_BITS    = 3,
   parameter int MEM_COL_BITS    = 3,
   parameter int SELF_ENTRY_CYC  = 10000,
   parameter int SELF_PERIOD_CYC = 1563,
   parameter bit EDO_HOLD        = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ras_n,
   input  logic                  cas_n,
   input  logic                  we_n,
   input  logic                  oe_n,
   input  logic [ROW_ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]       dq_in,
   output logic [DQ_W-1:0]       dq_out,
   output logic                  dq_oe,
   output logic [3:0]            cyc_type,
   output logic                  test_mode,
   output logic                  self_refresh,
   output logic [ROW_ADDR_W-1:0] rfsh_ctr,
   output logic [ROW_ADDR_W-1:0] last_ref_row
);

   localparam int TEST_KEY_BITS = 10;
   localparam int MEM_AW        = MEM_ROW_BITS + MEM_COL_BITS;

   initial begin
      assert (ROW_ADDR_W >= TEST_KEY_BITS) else $error("row address narrower than test key");
      assert (MEM_ROW_BITS <= ROW_ADDR_W && MEM_COL_BITS <= ROW_ADDR_W)
         else $error("array index wider than address");
      assert (DQ_W >= 1) else $error("DQ_W must be positive");
   end

   logic                  ras_low, cas_low, we_low, oe_low;
   logic                  ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
   logic [ROW_ADDR_W-1:0] addr_q;
   logic [DQ_W-1:0]       din_q;

   dram_strobe_sampler #(.ADDR_W(ROW_ADDR_W), .DQ_W(DQ_W)) u_smp (
      .clk(clk), .rst_n(rst_n),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .din(dq_in),
      .ras_low(ras_low), .cas_low(cas_low), .we_low(we_low), .oe_low(oe_low),
      .addr_q(addr_q), .din_q(din_q),
      .ras_fall(ras_fall), .ras_rise(ras_rise),
      .cas_fall(cas_fall), .cas_rise(cas_rise), .we_fall(we_fall)
   );

   cyc_e                    cyc_q;
   logic                    test_q;
   logic                    out_valid;
   logic                    page_cas_q;
   logic [MEM_ROW_BITS-1:0] row_q;
   logic [MEM_COL_BITS-1:0] col_q;
   logic                    self_act;

   // row strobe fall classification
   logic test_hit, hidden_hit, cbr_hit, row_hit, bump;
   assign test_hit   = ras_fall && cas_low && we_low && (&addr_q[TEST_KEY_BITS-1:0]);
   assign hidden_hit = ras_fall && cas_low && page_cas_q && !test_hit;
   assign cbr_hit    = ras_fall && cas_low && !page_cas_q && !test_hit;
   assign row_hit    = ras_fall && !cas_low;
   assign bump       = test_hit || hidden_hit || cbr_hit;

   // column and write strobe events inside an open row
   logic access_cas, rdwr_hit, drop;
   assign access_cas = cas_fall && ras_low;
   assign rdwr_hit   = we_fall && cas_low && ras_low && (cyc_q == CYC_READ);

   generate
      if (EDO_HOLD) begin : g_edo
         assign drop = !ras_low && !cas_low;
      end else begin : g_fpm
         assign drop = cas_rise || (!ras_low && !cas_low);
      end
   endgenerate

   dram_refresh_ctr #(
      .ROW_W(ROW_ADDR_W), .ENTRY_CYC(SELF_ENTRY_CYC), .PERIOD_CYC(SELF_PERIOD_CYC)
   ) u_ref (
      .clk(clk), .rst_n(rst_n),
      .cbr_start(cbr_hit), .bump(bump),
      .ras_low(ras_low), .cas_low(cas_low),
      .row(rfsh_ctr), .self_active(self_act)
   );

   // array port selection
   logic [MEM_COL_BITS-1:0] col_now;
   logic [MEM_AW-1:0]       rd_addr, wr_addr;
   logic                    rd_en, wr_en;
   logic [DQ_W-1:0]         rd_data;

   assign col_now = addr_q[MEM_COL_BITS-1:0];
   assign rd_en   = access_cas && !we_low;
   assign wr_en   = (access_cas && we_low) || rdwr_hit;
   assign rd_addr = {row_q, col_now};
   assign wr_addr = access_cas ? {row_q, col_now} : {row_q, col_q};

   dram_cell_array #(.AW(MEM_AW), .DQ_W(DQ_W)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .rd_en(rd_en), .rd_addr(rd_addr),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(din_q),
      .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q        <= CYC_IDLE;
         test_q       <= 1'b0;
         row_q        <= '0;
         col_q        <= '0;
         last_ref_row <= '0;
      end else begin
         if (test_hit) begin
            cyc_q        <= CYC_TESTIN;
            test_q       <= 1'b1;
            last_ref_row <= rfsh_ctr;
         end else if (hidden_hit || cbr_hit) begin
            cyc_q        <= hidden_hit ? CYC_HIDDEN : CYC_CBR;
            test_q       <= 1'b0;
            last_ref_row <= rfsh_ctr;
         end else if (row_hit) begin
            cyc_q        <= CYC_ROWREF;
            row_q        <= addr_q[MEM_ROW_BITS-1:0];
            last_ref_row <= addr_q;
         end else if (access_cas) begin
            cyc_q <= we_low ? CYC_EWRITE : CYC_READ;
            col_q <= col_now;
         end else if (rdwr_hit) begin
            cyc_q <= CYC_RDWR;
         end else if (ras_rise && cyc_q == CYC_ROWREF) begin
            test_q <= 1'b0;
         end
      end
   end

   // data pin drive and column strobe ownership
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         page_cas_q <= 1'b0;
      end else begin
         if (access_cas) begin
            out_valid <= !we_low;
         end else if (rdwr_hit || drop) begin
            out_valid <= 1'b0;
         end
         if (access_cas) begin
            page_cas_q <= 1'b1;
         end else if (cas_rise) begin
            page_cas_q <= 1'b0;
         end
      end
   end

   assign dq_out       = rd_data;
   assign dq_oe        = out_valid && oe_low;
   assign cyc_type     = self_act ? CYC_SELF : cyc_q;
   assign test_mode    = test_q;
   assign self_refresh = self_act;

   // R4
   test_entry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_q) |-> cyc_q == CYC_TESTIN);

   // R9
   off_both_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_low && !cas_low) |=> !out_valid);

   // R7
   ewrite_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == CYC_EWRITE) |-> !out_valid);

   // R13
   rowref_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q == CYC_ROWREF) |-> $stable(rfsh_ctr));

endmodule

// File: tb/dram_strobe_ctrl_tb.sv
module dram_strobe_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ROW_W      = 12;
   localparam int DQ_W       = 4;
   localparam int MRB        = 3;
   localparam int MCB        = 3;
   localparam int ENTRY      = 40;
   localparam int PERIOD     = 8;
   localparam int WATCHDOG   = 200000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b0;
   logic [ROW_W-1:0] addr = '0;
   logic [DQ_W-1:0]  dq_in = '0;
   logic [DQ_W-1:0]  dq_out;
   logic             dq_oe;
   logic [3:0]       cyc_type;
   logic             test_mode, self_refresh;
   logic [ROW_W-1:0] rfsh_ctr, last_ref_row;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   int exp_ctr = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dram_strobe_ctrl #(
      .ROW_ADDR_W(ROW_W), .DQ_W(DQ_W), .MEM_ROW_BITS(MRB), .MEM_COL_BITS(MCB),
      .SELF_ENTRY_CYC(ENTRY), .SELF_PERIOD_CYC(PERIOD), .EDO_HOLD(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .cyc_type(cyc_type),
      .test_mode(test_mode), .self_refresh(self_refresh),
      .rfsh_ctr(rfsh_ctr), .last_ref_row(last_ref_row)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [DQ_W-1:0] pat(input int r, input int c);
      return DQ_W'(r * 5 + c * 3 + 7);
   endfunction

   task automatic do_write(input int r, input int c, input logic [DQ_W-1:0] d);
      addr = ROW_W'(r); ras_n = 1'b0; step(2);
      addr = ROW_W'(c); we_n = 1'b0; dq_in = d; cas_n = 1'b0; step(2);
      chk("R7 early write type", cyc_type, 2);
      chk("R7 early write no drive", dq_oe, 0);
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step(2);
   endtask

   task automatic do_read(input int r, input int c, output logic [DQ_W-1:0] d,
                          output logic oe, output logic [3:0] t);
      addr = ROW_W'(r); ras_n = 1'b0; step(2);
      addr = ROW_W'(c); cas_n = 1'b0; step(2);
      d = dq_out; oe = dq_oe; t = cyc_type;
      ras_n = 1'b1; cas_n = 1'b1; step(2);
   endtask

   task automatic do_cbr(input logic [ROW_W-1:0] a);
      cas_n = 1'b0; step(2);
      addr = a; ras_n = 1'b0; step(2);
      ras_n = 1'b1; step(1);
      cas_n = 1'b1; step(2);
      exp_ctr = (exp_ctr + 1) % (1 << ROW_W);
   endtask

   task automatic do_wcbr(input logic [ROW_W-1:0] a);
      cas_n = 1'b0; we_n = 1'b0; step(2);
      addr = a; ras_n = 1'b0; step(2);
      exp_ctr = (exp_ctr + 1) % (1 << ROW_W);
   endtask

   task automatic end_wcbr();
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step(2);
   endtask

   initial begin
      logic [DQ_W-1:0] d;
      logic            oe;
      logic [3:0]      t;
      int              c0;

      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      chk("R1 type", cyc_type, 0);
      chk("R1 test", test_mode, 0);
      chk("R1 self", self_refresh, 0);
      chk("R1 ctr", rfsh_ctr, 0);
      chk("R1 oe", dq_oe, 0);

      // R7 / R6 full sweep of the small array
      for (int r = 0; r < (1 << MRB); r++)
         for (int c = 0; c < (1 << MCB); c++)
            do_write(r, c, pat(r, c));
      for (int r = 0; r < (1 << MRB); r++)
         for (int c = 0; c < (1 << MCB); c++) begin
            do_read(r, c, d, oe, t);
            chk("R6 read data", d, pat(r, c));
            if (r == 0) begin
               chk("R6 read drive", oe, 1);
               chk("R6 read type", t, 1);
            end
         end

      // R8 read-write
      addr = ROW_W'(2); ras_n = 1'b0; step(2);
      addr = ROW_W'(5); cas_n = 1'b0; step(2);
      chk("R8 read part data", dq_out, pat(2, 5));
      chk("R8 read part drive", dq_oe, 1);
      dq_in = 4'hA; we_n = 1'b0; step(2);
      chk("R8 type", cyc_type, 3);
      chk("R8 drive off", dq_oe, 0);
      ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; step(2);
      do_read(2, 5, d, oe, t);
      chk("R8 stored", d, 4'hA);

      // R9 extended data hold
      addr = ROW_W'(3); ras_n = 1'b0; step(2);
      addr = ROW_W'(1); cas_n = 1'b0; step(2);
      cas_n = 1'b1; step(2);
      chk("R9 hold drive", dq_oe, 1);
      chk("R9 hold data", dq_out, pat(3, 1));
      oe_n = 1'b1; step(1);
      chk("R9 oe high off", dq_oe, 0);
      oe_n = 1'b0; step(1);
      chk("R9 oe low on", dq_oe, 1);
      ras_n = 1'b1; step(2);
      chk("R9 both high off", dq_oe, 0);
      step(1);

      // R10 hidden refresh
      addr = ROW_W'(4); ras_n = 1'b0; step(2);
      addr = ROW_W'(6); cas_n = 1'b0; step(2);
      ras_n = 1'b1; step(2);
      chk("R10 drive across ras high", dq_oe, 1);
      ras_n = 1'b0; step(2);
      exp_ctr++;
      chk("R10 type", cyc_type, 6);
      chk("R10 ctr", rfsh_ctr, exp_ctr);
      chk("R10 drive", dq_oe, 1);
      chk("R10 data", dq_out, pat(4, 6));
      ras_n = 1'b1; cas_n = 1'b1; step(2);

      // R2 column-before-row refresh ignores address
      c0 = exp_ctr;
      do_cbr(12'h0C3);
      chk("R2 ctr", rfsh_ctr, exp_ctr);
      chk("R2 type", cyc_type, 5);
      chk("R2 refreshed row", last_ref_row, c0);
      do_cbr(12'hFFF & 12'h5E1);
      chk("R2 ctr again", rfsh_ctr, exp_ctr);
      do_read(0, 3, d, oe, t);
      chk("R2 array untouched", d, pat(0, 3));

      // R13 row-only refresh
      addr = 12'hB6D; ras_n = 1'b0; step(2);
      chk("R13 type", cyc_type, 4);
      chk("R13 row", last_ref_row, 12'hB6D);
      chk("R13 ctr", rfsh_ctr, exp_ctr);
      ras_n = 1'b1; step(2);

      // R4 / R5 test mode
      do_wcbr(12'h3EF);
      chk("R4 bad key type", cyc_type, 5);
      chk("R4 bad key no test", test_mode, 0);
      end_wcbr();
      do_wcbr(12'hC00 | 12'h3FF);
      chk("R4 entry type", cyc_type, 8);
      chk("R4 entry test", test_mode, 1);
      chk("R4 entry ctr", rfsh_ctr, exp_ctr);
      end_wcbr();
      do_wcbr(12'h3FF);
      chk("R5 re-entry keeps test", test_mode, 1);
      end_wcbr();
      addr = 12'h021; ras_n = 1'b0; step(2);
      chk("R5 row-only still test", test_mode, 1);
      ras_n = 1'b1; step(2);
      chk("R5 row-only exit", test_mode, 0);
      do_wcbr(12'h3FF); end_wcbr();
      do_cbr(12'h000);
      chk("R5 cbr exit", test_mode, 0);
      do_wcbr(12'h3FF); end_wcbr();
      addr = ROW_W'(1); ras_n = 1'b0; step(2);
      addr = ROW_W'(2); cas_n = 1'b0; step(2);
      ras_n = 1'b1; step(2);
      ras_n = 1'b0; step(2);
      exp_ctr++;
      chk("R5 hidden exit", test_mode, 0);
      ras_n = 1'b1; cas_n = 1'b1; step(2);

      // R11 aborted entry
      cas_n = 1'b0; step(2);
      ras_n = 1'b0; step(10);
      exp_ctr++;
      cas_n = 1'b1; step(ENTRY + 5);
      chk("R11 no entry", self_refresh, 0);
      ras_n = 1'b1; step(2);

      // R11 / R12 self refresh
      cas_n = 1'b0; step(2);
      ras_n = 1'b0; step(2);
      exp_ctr++;
      chk("R12 start ctr", rfsh_ctr, exp_ctr);
      step(ENTRY - 1);
      chk("R11 before entry", self_refresh, 0);
      step(1);
      chk("R11 entry", self_refresh, 1);
      chk("R11 type", cyc_type, 7);
      step(PERIOD - 1);
      chk("R12 before tick", rfsh_ctr, exp_ctr);
      step(1);
      exp_ctr++;
      chk("R12 first tick", rfsh_ctr, exp_ctr);
      step(3 * PERIOD);
      exp_ctr += 3;
      chk("R12 later ticks", rfsh_ctr, exp_ctr);
      ras_n = 1'b1; step(2);
      chk("R11 exit", self_refresh, 0);
      chk("R12 no tick at exit", rfsh_ctr, exp_ctr);
      cas_n = 1'b1; step(2);

      // R3 wrap
      while (exp_ctr != (1 << ROW_W) - 1) do_cbr(12'h000);
      chk("R3 all ones", rfsh_ctr, (1 << ROW_W) - 1);
      do_cbr(12'h000);
      chk("R3 wrap", rfsh_ctr, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule